// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block is the host-side controller for a 128-pixel linear photodiode array. It divides the system clock down to a sensor clock and raises the sensor's start line so that exactly one sensor rising edge captures it. It then counts the 129 rising edges that a readout frame needs. On the falling edge that follows each of the first 128 of those edges, it pulses a one-cycle ADC sample strobe and tags it with the pixel index. The strobe falls in the second half of the pixel period, so the sensor output has had half a period to settle.

The sensor clock keeps running between frames. The time from one start capture to the next is held at max(integration setting + 18, 129) rising edges. The 18 edges cover the interval in which the sensor resets its integrators after a start pulse, so the requested integration time is what the sensor actually integrates. The 129-edge floor keeps the next start pulse off the sensor clock until its 130th edge. A frame is launched by a one-cycle request, or repeatedly while free-run is held high.

The controller has four states:
- IDLE: no frame is in progress.
- ARM: the start line is high and waits for its capturing edge.
- READ: the controller counts edges and issues strobes.
- GAP: the controller counts the spacing before the next capture is allowed.

The transitions are:
- IDLE→ARM, on a sensor falling edge while a request is pending or free-run is high.
- ARM→READ, on the next rising edge, which captures the start line.
- READ→GAP, on the 129th rising edge, which also pulses frame-done.
- GAP→ARM, on a falling edge once the spacing is met, if another frame is wanted.
- GAP→IDLE, on a falling edge once the spacing is met, if no further frame is wanted.

Top module: `lsr_readout_seq`

## Requirements
- R1: The sensor clock holds each level for `half_div` system clock cycles, so a full period is 2×`half_div`; a setting of 0 is treated as 1.
- R2: The start line changes only in the cycle in which the sensor clock falls, and it is high on exactly one sensor rising edge per frame.
- R3: `frame_done` is a one-cycle pulse coinciding with the sensor clock's rising edge, and that edge is the 129th of the frame when the start-capturing edge is counted as edge 1.
- R4: Each frame produces exactly 128 `sample_stb` pulses. Each pulse coincides with a sensor clock falling edge. `pix_idx` counts 0 to 127 in ascending order.
- R5: `busy` rises in the cycle the start line rises and falls in the cycle `frame_done` pulses.
- R6: In free-run, consecutive start captures are exactly max(`integ_clks` + 18, 129) sensor rising edges apart.
- R7: A one-cycle `start_req` pulse with free-run low produces exactly one frame and no further frame.
- R8: During reset, the sensor clock, start line, strobe, frame-done and busy outputs are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | One-cycle request for a single frame |
| free_run | input | 1 | Repeat frames continuously while high |
| half_div | input | DIV_W | Sensor clock half period in system cycles |
| integ_clks | input | INT_W | Requested integration time in sensor clocks |
| sclk | output | 1 | Sensor clock |
| si | output | 1 | Sensor start line |
| sample_stb | output | 1 | ADC sample strobe, one system cycle |
| pix_idx | output | IDX_W | Pixel index qualifying `sample_stb` |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | High while a frame is being read out |

## Verification
The bench uses the default geometry of 128 pixels and an 18-edge reset interval. The divider is set to 2 and also to 0, which brings a full frame into a few hundred system cycles and reaches the clamp of the divider's lower bound. Integration settings of 5, 111, 112 and 200 fall on each side of the point where the 129-edge floor gives way to the integration-driven spacing. This exposes off-by-one errors in the spacing comparison.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_READ = 2'd2,
        ST_GAP  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/lsr_clkgen.sv
// Sensor clock generator: each level lasts half_div system cycles.
// rise_now / fall_now flag the cycle whose closing edge toggles sclk.
module lsr_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    output logic             sclk,
    output logic             rise_now,
    output logic             fall_now
);
    logic [DIV_W-1:0] cnt_q;
    logic             sclk_q;
    logic [DIV_W-1:0] half_eff;
    logic             tick;

    assign half_eff = (half_div == '0) ? DIV_W'(1) : half_div;
    assign tick     = (cnt_q >= half_eff - DIV_W'(1));
    assign rise_now = tick && !sclk_q;
    assign fall_now = tick && sclk_q;
    assign sclk     = sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/lsr_spacing.sv
// Edges between start captures: max(integration + reset interval, frame length).
module lsr_spacing #(
    parameter int INT_W       = 16,
    parameter int CW          = 18,
    parameter int RST_CLKS    = 18,
    parameter int FRAME_EDGES = 129
) (
    input  logic [INT_W-1:0] integ_clks,
    output logic [CW-1:0]    spacing
);
    logic [CW-1:0] sum;

    assign sum     = CW'(integ_clks) + CW'(RST_CLKS);
    assign spacing = (sum < CW'(FRAME_EDGES)) ? CW'(FRAME_EDGES) : sum;
endmodule

// File: rtl/lsr_readout_seq.sv
module lsr_readout_seq
    import lsr_pkg::*;
#(
    parameter int NUM_PIX  = 128,
    parameter int RST_CLKS = 18,
    parameter int DIV_W    = 8,
    parameter int INT_W    = 16,
    parameter int IDX_W    = $clog2(NUM_PIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             free_run,
    input  logic [DIV_W-1:0] half_div,
    input  logic [INT_W-1:0] integ_clks,
    output logic             sclk,
    output logic             si,
    output logic             sample_stb,
    output logic [IDX_W-1:0] pix_idx,
    output logic             frame_done,
    output logic             busy
);
    localparam int FRAME_EDGES = NUM_PIX + 1;
    localparam int CW          = INT_W + 2;

    seq_state_t       state_q, state_d;
    logic [CW-1:0]    ec_q;        // rising edges since capture (capture = 1)
    logic             pend_q;
    logic [CW-1:0]    spacing;
    logic             rise_now, fall_now;
    logic             go, launch, stb_d;

    logic             si_q, stb_q, done_q, busy_q;
    logic [IDX_W-1:0] idx_q;

    lsr_clkgen #(.DIV_W(DIV_W)) clkgen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_div (half_div),
        .sclk     (sclk),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    lsr_spacing #(
        .INT_W       (INT_W),
        .CW          (CW),
        .RST_CLKS    (RST_CLKS),
        .FRAME_EDGES (FRAME_EDGES)
    ) spacing_i (
        .integ_clks (integ_clks),
        .spacing    (spacing)
    );

    assign go = pend_q || free_run;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fall_now && go) state_d = ST_ARM;
            ST_ARM:  if (rise_now) state_d = ST_READ;
            ST_READ: if (rise_now && ec_q == CW'(NUM_PIX)) state_d = ST_GAP;
            ST_GAP:  if (fall_now && ec_q >= spacing) state_d = go ? ST_ARM : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign launch = (state_d == ST_ARM) && (state_q != ST_ARM);
    assign stb_d  = (state_q == ST_READ) && fall_now && (ec_q <= CW'(NUM_PIX));

    // State register, edge counter and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ec_q    <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ARM && rise_now)
                ec_q <= CW'(1);
            else if (rise_now && (state_q == ST_READ ||
                                  (state_q == ST_GAP && ec_q < spacing)))
                ec_q <= ec_q + CW'(1);
            if (start_req)
                pend_q <= 1'b1;
            else if (launch)
                pend_q <= 1'b0;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            si_q   <= 1'b0;
            stb_q  <= 1'b0;
            done_q <= 1'b0;
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            if (launch)
                si_q <= 1'b1;
            else if (state_q == ST_READ && fall_now)
                si_q <= 1'b0;
            stb_q  <= stb_d;
            if (stb_d)
                idx_q <= IDX_W'(ec_q - CW'(1));
            done_q <= (state_q == ST_READ) && (state_d == ST_GAP);
            busy_q <= (state_d == ST_ARM) || (state_d == ST_READ);
        end
    end

    assign si         = si_q;
    assign sample_stb = stb_q;
    assign pix_idx    = idx_q;
    assign frame_done = done_q;
    assign busy       = busy_q;
endmodule

// File: rtl/lsr_readout_seq_chk.sv
module lsr_readout_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic si,
    input logic sample_stb,
    input logic frame_done,
    input logic busy
);
    assert_si_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (si != $past(si)) |-> ($past(sclk) && !sclk));

    assert_done_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (sclk && !$past(sclk)));

    assert_stb_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> ($past(sclk) && !sclk));

    assert_stb_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> busy);

    assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!busy && $past(busy)));

    assert_busy_with_si_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(si) |-> busy);
endmodule

bind lsr_readout_seq lsr_readout_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .si         (si),
    .sample_stb (sample_stb),
    .frame_done (frame_done),
    .busy       (busy)
);

// File: tb/lsr_readout_seq_tb_top.sv
module lsr_readout_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W = 8;
    localparam int INT_W = 16;
    localparam int IDX_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0;
    logic free_run = 1'b0;
    logic [DIV_W-1:0] half_div = 8'd2;
    logic [INT_W-1:0] integ_clks = '0;
    logic sclk, si, sample_stb, frame_done, busy;
    logic [IDX_W-1:0] pix_idx;

    lsr_readout_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .free_run(free_run),
        .half_div(half_div), .integ_clks(integ_clks), .sclk(sclk), .si(si),
        .sample_stb(sample_stb), .pix_idx(pix_idx), .frame_done(frame_done),
        .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Port monitor, sampled on the falling system clock edge
    int rise_total = 0, last_cap = 0, caps = 0, last_gap = 0, exp_gap = 129;
    int gap_err = 0, dbl_err = 0, stb_cnt = 0, idx_err = 0, phase_err = 0;
    int si_err = 0, done_cnt = 0, done_len = 0, busy_err = 0, exp_idx = 0;
    logic prev_sclk = 1'b0, prev_si = 1'b0, prev_rise_si = 1'b0;
    logic m_rise, m_fall;

    always @(negedge clk) begin
        if (rst_n) begin
            m_rise = sclk && !prev_sclk;
            m_fall = !sclk && prev_sclk;
            if (si != prev_si && !m_fall) si_err++;
            if (si && !prev_si && !busy) busy_err++;
            if (m_rise) begin
                rise_total++;
                if (si && prev_rise_si) dbl_err++;
                if (si) begin
                    if (caps > 0) begin
                        last_gap = rise_total - last_cap;
                        if (last_gap != exp_gap) gap_err++;
                    end
                    caps++;
                    last_cap = rise_total;
                    exp_idx = 0;
                end
                prev_rise_si = si;
            end
            if (sample_stb) begin
                stb_cnt++;
                if (!m_fall) phase_err++;
                if (int'(pix_idx) != exp_idx) idx_err++;
                exp_idx++;
            end
            if (frame_done) begin
                done_cnt++;
                done_len = rise_total - last_cap + 1;
                if (!m_rise) phase_err++;
                if (busy) busy_err++;
            end
            prev_sclk = sclk;
            prev_si = si;
        end
    end

    task automatic mon_clear();
        caps = 0; gap_err = 0; dbl_err = 0; stb_cnt = 0; idx_err = 0;
        phase_err = 0; si_err = 0; done_cnt = 0; done_len = 0; busy_err = 0;
        last_gap = 0;
    endtask

    // R8: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        check(sclk == 1'b0, "R8", "sclk in reset", int'(sclk), 0);
        check(si == 1'b0 && sample_stb == 1'b0, "R8", "si|stb in reset",
              int'(si | sample_stb), 0);
        check(busy == 1'b0 && frame_done == 1'b0, "R8", "busy|done in reset",
              int'(busy | frame_done), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: sensor clock period
    task automatic t_divider(input int d, input int exp_cycles);
        logic p;
        int n;
        half_div = DIV_W'(d);
        repeat (20) @(negedge clk);
        p = sclk;
        forever begin
            @(negedge clk);
            if (sclk && !p) break;
            p = sclk;
        end
        n = 0;
        p = sclk;
        forever begin
            @(negedge clk);
            n++;
            if (sclk && !p) break;
            p = sclk;
        end
        check(n == exp_cycles, "R1", "sclk period cycles", n, exp_cycles);
    endtask

    // R7, R3, R4, R2, R5: one requested frame
    task automatic t_single();
        int t;
        half_div = 8'd2;
        integ_clks = '0;
        free_run = 1'b0;
        exp_gap = 129;
        @(posedge clk);
        mon_clear();
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        t = 0;
        while (done_cnt < 1 && t < 3000) begin
            @(posedge clk);
            t++;
        end
        repeat (1500) @(posedge clk);
        check(caps == 1, "R7", "frames from one request", caps, 1);
        check(done_cnt == 1, "R7", "frame_done pulses", done_cnt, 1);
        check(done_len == 129, "R3", "edges per frame", done_len, 129);
        check(stb_cnt == 128, "R4", "strobes per frame", stb_cnt, 128);
        check(idx_err == 0, "R4", "pixel index order errors", idx_err, 0);
        check(phase_err == 0, "R4", "strobe/done edge alignment errors", phase_err, 0);
        check(si_err == 0, "R2", "si changes off falling edge", si_err, 0);
        check(dbl_err == 0, "R2", "si high on two rises", dbl_err, 0);
        check(busy_err == 0, "R5", "busy framing errors", busy_err, 0);
        check(busy == 1'b0, "R5", "busy after frame", int'(busy), 0);
    endtask

    // R6: free-run spacing between captures
    task automatic t_free(input int integ, input int exp_p);
        int t;
        integ_clks = INT_W'(integ);
        exp_gap = exp_p;
        @(posedge clk);
        mon_clear();
        @(negedge clk);
        free_run = 1'b1;
        t = 0;
        while (caps < 3 && t < 8000) begin
            @(posedge clk);
            t++;
        end
        @(negedge clk);
        free_run = 1'b0;
        t = 0;
        while (busy && t < 4000) begin
            @(posedge clk);
            t++;
        end
        repeat (10) @(posedge clk);
        check(last_gap == exp_p, "R6", "capture spacing", last_gap, exp_p);
        check(gap_err == 0, "R6", "spacing errors", gap_err, 0);
        check(stb_cnt == 128 * done_cnt && done_cnt >= 3, "R4",
              "strobes over frames", stb_cnt, 128 * done_cnt);
        check(done_len == 129, "R3", "edges in last frame", done_len, 129);
        check(si_err == 0 && dbl_err == 0, "R2", "start line errors",
              si_err + dbl_err, 0);
    endtask

    initial begin
        t_reset();
        t_divider(2, 4);
        t_divider(0, 2);
        t_divider(3, 6);
        t_single();
        t_free(5, 129);
        t_free(111, 129);
        t_free(112, 130);
        t_free(200, 218);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule